// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a clock-accurate model of the control path of a synchronous burst SRAM. Each word is four byte lanes of nine bits, eight data bits and one parity bit. On every rising clock edge it looks at three chip selects, a sleep input, two address strobes, a burst-advance input and the write enables. From these it picks one cycle type: power-down, deselect, begin a burst, continue a burst, or suspend a burst. The burst address is held in a register. Writes are masked per byte lane. Reads return through a pipelined output register.

The processor strobe always starts a read, and it is honoured only while the primary select is active. The controller strobe can start a read or a write. Once a burst is open, further cycles either step the two low address bits, in linear or interleaved order, or stay at the current address. The direction of each such cycle follows the combined write-enable term. The data bus is not modelled as an inout. Read data is presented on `rdata`, and `rdata_oe` says when a bus driver would be on. That enable is gated at once, with no clock, by the output-enable and sleep inputs.

Top module: `burst_sram_core`

## Requirements
- R1: While `sleep` is 1 the cycle is power-down, whatever the other inputs are. `rdata_oe` is 0 in the same cycle, no lane is written, and any open burst is closed.
- R2: When `sel_a_n`=1 and `strb_c_n`=0 the cycle is a deselect whatever `strb_p_n` is. Nothing is written, and `rdata_oe` is 0 in the following output slot.
- R3: With the primary select active (`sel_a_n`=0), either strobe low while `sel_b`=0 or `sel_c_n`=1 gives a deselect, with no write and no read data.
- R4: A begin cycle (all three selects active, `strb_p_n`=0, or `strb_p_n`=1 with `strb_c_n`=0) registers `addr`. For a read, the word at that address appears on `rdata` with `rdata_oe`=1 after the next rising edge, one clock after the address is registered.
- R5: A begin cycle started by `strb_p_n`=0 is always a read, whatever `gw_n`, `bwe_n` and `bw_n` are.
- R6: A begin cycle started by `strb_c_n`=0 with the write term active writes `wdata` at `addr` on that edge.
- R7: The write term is active when `gw_n`=0, which writes all lanes, or when `bwe_n`=0 with some `bw_n[i]`=0, which writes lane i, bits [9i+8:9i]. With `bwe_n`=1, or with all `bw_n` high and `gw_n`=1, the cycle is a read.
- R8: With both strobes high (or `sel_a_n`=1 and `strb_c_n`=1), `adv_n`=0 and a burst open, the cycle uses the next address. With `ilv_mode`=0 latched at the begin cycle, the two low bits step as base+1, +2, +3 modulo 4. The upper bits do not change.
- R9: With `ilv_mode`=1 latched at the begin cycle, the low two bits follow base XOR 0, 1, 2, 3.
- R10: With both strobes high and `adv_n`=1, the burst stays at the current address. It reads or writes there according to the write term.
- R11: `rdata_oe` is 1 only when the current output slot holds read data and `oe_n`=0. It follows `oe_n` within the same cycle, and it is 0 in the slot after a write cycle.
- R12: Continue and suspend cycles have no effect when no burst is open, that is after reset, a deselect or a sleep: no write and no read data.
- R13: After reset no burst is open, `rdata_oe` is 0 and the array reads as all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_n | input | 1 | Primary chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Secondary chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| sleep | input | 1 | Power-down request, overrides all other inputs |
| strb_p_n | input | 1 | Processor address strobe, active low, read-only start |
| strb_c_n | input | 1 | Controller address strobe, active low, read or write start |
| adv_n | input | 1 | Burst advance, low steps, high suspends |
| gw_n | input | 1 | Global write, active low, all lanes |
| bwe_n | input | 1 | Byte write qualifier, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, unclocked |
| ilv_mode | input | 1 | Burst order latched at begin: 0 linear, 1 interleaved |
| addr | input | AW | External word address |
| wdata | input | LANES*LANE_W | Write data, lane i at bits [9i+8:9i] |
| rdata | output | LANES*LANE_W | Pipelined read data |
| rdata_oe | output | 1 | Data-bus drive enable |

## Verification
The hardest situation to reach is a write that follows a processor-strobe start. The start cycle must ignore active write enables and read the old word. The suspend cycle right after it must then write the same address while the old word leaves the pipeline. The stimulus holds `gw_n` low across both cycles. It checks the old data in the output slot, then reads the address back. Also awkward are burst cycles issued after a deselect or sleep has closed the burst. The bench drives continue and suspend writes there, then reads back every address they could have touched.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
   typedef enum logic [2:0] {
      CY_SLEEP    = 3'd0,
      CY_DESEL    = 3'd1,
      CY_BEGIN_RD = 3'd2,
      CY_BEGIN_WR = 3'd3,
      CY_CONT     = 3'd4,
      CY_SUSP     = 3'd5
   } cyc_e;
endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
   import sbr_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             sel_a_n,
   input  logic             sel_b,
   input  logic             sel_c_n,
   input  logic             sleep,
   input  logic             strb_p_n,
   input  logic             strb_c_n,
   input  logic             adv_n,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output cyc_e             cyc,
   output logic             wr_any,
   output logic [LANES-1:0] lane_en
);
   logic chip_ok;

   // lane write mask: global write wins, else byte writes qualified by bwe_n
   always_comb begin
      if (!gw_n)       lane_en = '1;
      else if (!bwe_n) lane_en = ~bw_n;
      else             lane_en = '0;
   end
   assign wr_any  = |lane_en;
   assign chip_ok = !sel_a_n && sel_b && !sel_c_n;

   // priority: sleep, deselect by primary select, processor strobe, controller strobe, burst
   always_comb begin
      if (sleep)                       cyc = CY_SLEEP;
      else if (sel_a_n && !strb_c_n)   cyc = CY_DESEL;
      else if (!sel_a_n && !strb_p_n)  cyc = chip_ok ? CY_BEGIN_RD : CY_DESEL;
      else if (!strb_c_n)              cyc = !chip_ok ? CY_DESEL :
                                             (wr_any ? CY_BEGIN_WR : CY_BEGIN_RD);
      else                             cyc = adv_n ? CY_SUSP : CY_CONT;
   end
endmodule

// File: rtl/sbr_burst_ctr.sv
module sbr_burst_ctr #(
   parameter int AW      = 6,
   parameter bit HAS_ILV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          ilv_in,
   input  logic [AW-1:0] ext_addr,
   output logic [AW-1:0] used_addr,
   output logic [AW-1:0] cur_q
);
   logic [AW-1:0] base_q;
   logic [1:0]    cnt_q;
   logic [1:0]    cnt_n;
   logic          ilv_q;
   logic [1:0]    lo_cur;
   logic [1:0]    lo_nxt;

   assign cnt_n = cnt_q + 2'd1;

   if (HAS_ILV) begin : g_ilv
      assign lo_cur = ilv_q ? (base_q[1:0] ^ cnt_q) : (base_q[1:0] + cnt_q);
      assign lo_nxt = ilv_q ? (base_q[1:0] ^ cnt_n) : (base_q[1:0] + cnt_n);
   end else begin : g_lin
      assign lo_cur = base_q[1:0] + cnt_q;
      assign lo_nxt = base_q[1:0] + cnt_n;
   end

   assign cur_q     = {base_q[AW-1:2], lo_cur};
   assign used_addr = load ? ext_addr : {base_q[AW-1:2], (step ? lo_nxt : lo_cur)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         ilv_q  <= 1'b0;
      end else if (load) begin
         base_q <= ext_addr;
         cnt_q  <= '0;
         ilv_q  <= HAS_ILV ? ilv_in : 1'b0;
      end else if (step) begin
         cnt_q  <= cnt_n;
      end
   end
endmodule

// File: rtl/sbr_array.sv
module sbr_array #(
   parameter int AW     = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [LANES-1:0]        lane_en,
   input  logic [AW-1:0]           waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    re,
   input  logic [AW-1:0]           raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] dout_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            dout_q <= '0;
         end else begin
            if (we && lane_en[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            if (re)               dout_q     <= mem[raddr];
         end
      end
      assign rdata[g*LANE_W +: LANE_W] = dout_q;
   end
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
   import sbr_pkg::*;
#(
   parameter int AW      = 6,
   parameter int LANES   = 4,
   parameter int LANE_W  = 9,
   parameter bit HAS_ILV = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    sleep,
   input  logic                    strb_p_n,
   input  logic                    strb_c_n,
   input  logic                    adv_n,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic                    oe_n,
   input  logic                    ilv_mode,
   input  logic [AW-1:0]           addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);
   if (AW < 2) begin : g_bad_aw
      $error("burst_sram_core: AW must be at least 2");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("burst_sram_core: LANES and LANE_W must be positive");
   end

   cyc_e             cyc;
   logic             wr_any;
   logic [LANES-1:0] lane_en;
   logic             active_q;
   logic             in_burst;
   logic             load;
   logic             do_wr;
   logic             do_rd;
   logic [AW-1:0]    used_addr;
   logic [AW-1:0]    cur_q;
   logic [AW-1:0]    rd_addr_q;
   logic             rd_pend_q;
   logic             out_v_q;

   sbr_decode #(.LANES(LANES)) u_dec (
      .sel_a_n (sel_a_n),  .sel_b   (sel_b),    .sel_c_n (sel_c_n),
      .sleep   (sleep),    .strb_p_n(strb_p_n), .strb_c_n(strb_c_n),
      .adv_n   (adv_n),    .gw_n    (gw_n),     .bwe_n   (bwe_n),
      .bw_n    (bw_n),     .cyc     (cyc),      .wr_any  (wr_any),
      .lane_en (lane_en)
   );

   assign load     = (cyc == CY_BEGIN_RD) || (cyc == CY_BEGIN_WR);
   assign in_burst = active_q && ((cyc == CY_CONT) || (cyc == CY_SUSP));
   assign do_wr    = (cyc == CY_BEGIN_WR) || (in_burst && wr_any);
   assign do_rd    = (cyc == CY_BEGIN_RD) || (in_burst && !wr_any);

   sbr_burst_ctr #(.AW(AW), .HAS_ILV(HAS_ILV)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (active_q && (cyc == CY_CONT)),
      .ilv_in   (ilv_mode),
      .ext_addr (addr),
      .used_addr(used_addr),
      .cur_q    (cur_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         rd_pend_q <= 1'b0;
         rd_addr_q <= '0;
         out_v_q   <= 1'b0;
      end else begin
         if (load)                                          active_q <= 1'b1;
         else if ((cyc == CY_SLEEP) || (cyc == CY_DESEL))   active_q <= 1'b0;
         rd_pend_q <= do_rd;
         rd_addr_q <= used_addr;
         out_v_q   <= rd_pend_q;
      end
   end

   sbr_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (do_wr),
      .lane_en(lane_en),
      .waddr  (used_addr),
      .wdata  (wdata),
      .re     (rd_pend_q),
      .raddr  (rd_addr_q),
      .rdata  (rdata)
   );

   assign rdata_oe = out_v_q && !oe_n && !sleep;
endmodule

// File: rtl/sbr_chk.sv
module sbr_chk
   import sbr_pkg::*;
#(
   parameter int AW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sleep,
   input logic          oe_n,
   input logic          sel_a_n,
   input logic          strb_p_n,
   input logic          strb_c_n,
   input logic          rdata_oe,
   input cyc_e          cyc,
   input logic          active_q,
   input logic          do_wr,
   input logic          rd_pend_q,
   input logic [AW-1:0] cur_q
);
   a_r1_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (!rdata_oe && !do_wr));

   a_r2_desel_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a_n && !strb_c_n) |=> (!rd_pend_q && !active_q));

   a_r5_adsp_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_a_n && !strb_p_n) |-> !do_wr);

   a_r8_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && cyc == CY_CONT) |=> (cur_q[AW-1:2] == $past(cur_q[AW-1:2])));

   a_r10_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && cyc == CY_SUSP) |=> (cur_q == $past(cur_q)));

   a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rdata_oe);

   a_r12_idle_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && (cyc == CY_CONT || cyc == CY_SUSP)) |-> !do_wr);

   a_r12_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && (cyc == CY_CONT || cyc == CY_SUSP)) |=> !rd_pend_q);
endmodule

bind burst_sram_core sbr_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sleep    (sleep),
   .oe_n     (oe_n),
   .sel_a_n  (sel_a_n),
   .strb_p_n (strb_p_n),
   .strb_c_n (strb_c_n),
   .rdata_oe (rdata_oe),
   .cyc      (cyc),
   .active_q (active_q),
   .do_wr    (do_wr),
   .rd_pend_q(rd_pend_q),
   .cur_q    (cur_q)
);

// File: tb/burst_sram_core_tb.sv
`timescale 1ns/1ps
module burst_sram_core_tb;
   localparam int AW = 6, LANES = 4, LW = 9, DW = LANES*LW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sel_a_n, sel_b, sel_c_n, sleep, strb_p_n, strb_c_n, adv_n;
   logic gw_n, bwe_n, oe_n, ilv_mode;
   logic [LANES-1:0] bw_n;
   logic [AW-1:0]    addr;
   logic [DW-1:0]    wdata, rdata;
   logic             rdata_oe;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   logic [DW-1:0] refm [1<<AW];

   always #4 clk = ~clk;

   burst_sram_core #(.AW(AW), .LANES(LANES), .LANE_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .sleep(sleep), .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .ilv_mode(ilv_mode),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   task automatic tick; @(posedge clk); @(negedge clk); endtask

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] ord(logic [AW-1:0] b, bit ilv, int i);
      logic [1:0] k = 2'(i);
      return {b[AW-1:2], (ilv ? (b[1:0] ^ k) : (b[1:0] + k))};
   endfunction

   function automatic logic [DW-1:0] pat(int a);
      return DW'(36'h1_0203_0405) * DW'(a + 3) ^ DW'(36'h9_A5C3_3C5A);
   endfunction

   task automatic ref_wr(logic [AW-1:0] a, logic g, logic be, logic [LANES-1:0] bw, logic [DW-1:0] d);
      for (int i = 0; i < LANES; i++)
         if (!g || (!be && !bw[i])) refm[a][i*LW +: LW] = d[i*LW +: LW];
   endtask

   task automatic d_idle;
      sel_a_n = 1; sel_b = 1; sel_c_n = 0; sleep = 0; strb_p_n = 1; strb_c_n = 0;
      adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
   endtask
   task automatic d_adsp(logic [AW-1:0] a);
      sel_a_n = 0; sel_b = 1; sel_c_n = 0; strb_p_n = 0; strb_c_n = 1; addr = a;
   endtask
   task automatic d_adsc(logic [AW-1:0] a, logic g, logic be, logic [LANES-1:0] bw, logic [DW-1:0] d);
      sel_a_n = 0; sel_b = 1; sel_c_n = 0; strb_p_n = 1; strb_c_n = 0; addr = a;
      gw_n = g; bwe_n = be; bw_n = bw; wdata = d;
   endtask
   task automatic d_burst(logic adv, logic g, logic be, logic [LANES-1:0] bw, logic [DW-1:0] d);
      strb_p_n = 1; strb_c_n = 1; adv_n = adv; gw_n = g; bwe_n = be; bw_n = bw; wdata = d;
   endtask

   task automatic wr1(logic [AW-1:0] a, logic [DW-1:0] d);
      d_adsc(a, 0, 1, '1, d); ref_wr(a, 0, 1, '1, d); tick; d_idle;
   endtask

   task automatic read1(logic [AW-1:0] a, string tag);
      d_idle; d_adsp(a); tick; d_idle; tick;
      check(tag, rdata, refm[a]);
      check(tag, DW'(rdata_oe), DW'(1));
   endtask

   task automatic t_reset;
      read1(6'd5, "R13 reset array zero");
      d_idle; tick;
      check("R13 oe after idle", DW'(rdata_oe), DW'(0));
   endtask

   task automatic t_write_burst;
      d_idle;
      d_adsc(6'd10, 0, 1, '1, pat(10)); ref_wr(6'd10, 0, 1, '1, pat(10)); tick;
      for (int i = 1; i < 4; i++) begin
         d_burst(0, 0, 1, '1, pat(40 + i));
         ref_wr(ord(6'd10, 0, i), 0, 1, '1, pat(40 + i));
         tick;
         check("R11 no drive after write", DW'(rdata_oe), DW'(0));
      end
      d_idle; tick;
      read1(6'd10, "R6 begin write");
      read1(6'd11, "R8 write step 1");
      read1(6'd8,  "R8 write wrap");
      read1(6'd9,  "R8 write step 3");
   endtask

   task automatic rd_burst(logic [AW-1:0] b, bit ilv, string tag);
      d_idle; ilv_mode = ilv; d_adsp(b); tick;
      ilv_mode = ~ilv;
      for (int i = 1; i < 4; i++) begin
         d_burst(0, 1, 1, '1, '0); tick;
         check(tag, rdata, refm[ord(b, ilv, i - 1)]);
         check(tag, DW'(rdata_oe), DW'(1));
      end
      d_idle; tick;
      check(tag, rdata, refm[ord(b, ilv, 3)]);
      tick;
      check(tag, DW'(rdata_oe), DW'(0));
   endtask

   task automatic t_suspend;
      d_idle; ilv_mode = 0; d_adsp(6'd22); tick;
      d_burst(0, 1, 1, '1, '0); tick; check("R10 first", rdata, refm[22]);
      d_burst(1, 1, 1, '1, '0); tick; check("R10 step", rdata, refm[23]);
      d_burst(1, 1, 1, '1, '0); tick; check("R10 hold", rdata, refm[23]);
      d_burst(0, 1, 1, '1, '0); tick; check("R10 hold2", rdata, refm[23]);
      d_idle; tick;               check("R10 resume wrap", rdata, refm[20]);
   endtask

   task automatic t_adsp_ignores_write;
      logic [DW-1:0] old = refm[40];
      d_idle; d_adsp(6'd40); gw_n = 0; wdata = pat(77); tick;
      d_burst(1, 0, 1, '1, pat(88)); tick;
      check("R5 adsp reads old", rdata, old);
      ref_wr(6'd40, 0, 1, '1, pat(88));
      d_idle; tick;
      read1(6'd40, "R10 suspend write after adsp");
   endtask

   task automatic t_byte_mask;
      wr1(6'd30, pat(30));
      d_adsc(6'd30, 1, 0, 4'b1010, pat(31)); ref_wr(6'd30, 1, 0, 4'b1010, pat(31)); tick;
      d_adsc(6'd30, 1, 0, 4'b1111, pat(32)); tick; d_idle; tick;
      check("R7 lanes 0,2 only / bw all high reads", rdata, refm[30]);
      d_adsc(6'd30, 1, 1, 4'b0000, pat(33)); tick; d_idle; tick;
      check("R7 bw without bwe reads", rdata, refm[30]);
      d_adsc(6'd31, 1, 0, 4'b0111, pat(34)); ref_wr(6'd31, 1, 0, 4'b0111, pat(34)); tick;
      read1(6'd31, "R7 lane 3 only");
   endtask

   task automatic t_deselect;
      wr1(6'd44, pat(44)); wr1(6'd45, pat(45));
      d_idle; d_adsp(6'd44); sel_b = 0; tick; d_idle; tick;
      check("R3 adsp sel_b low", DW'(rdata_oe), DW'(0));
      d_adsp(6'd44); sel_c_n = 1; tick; d_idle; tick;
      check("R3 adsp sel_c high", DW'(rdata_oe), DW'(0));
      d_idle; strb_p_n = 0; gw_n = 0; addr = 6'd44; wdata = pat(99); tick; d_idle; tick;
      check("R2 adsp ignored when deselected", DW'(rdata_oe), DW'(0));
      read1(6'd44, "R2 no write");
      d_adsc(6'd44, 0, 1, '1, pat(98)); sel_b = 0; tick; d_idle; tick;
      check("R3 adsc deselect", DW'(rdata_oe), DW'(0));
      read1(6'd44, "R3 no write");
      d_idle; tick;
      d_burst(0, 0, 1, '1, pat(97)); tick;
      d_burst(1, 0, 1, '1, pat(96)); tick;
      d_burst(1, 1, 1, '1, '0); tick; d_idle; tick;
      check("R12 no read without burst", DW'(rdata_oe), DW'(0));
      read1(6'd44, "R12 no write 44");
      read1(6'd45, "R12 no write 45");
   endtask

   task automatic t_sleep;
      d_idle; ilv_mode = 0; d_adsp(6'd20); tick;
      d_burst(1, 1, 1, '1, '0); tick;
      check("R1 pre-sleep drive", DW'(rdata_oe), DW'(1));
      sleep = 1; #1;
      check("R1 sleep gates bus", DW'(rdata_oe), DW'(0));
      d_adsc(6'd20, 0, 1, '1, pat(55)); sleep = 1; tick;
      d_burst(0, 0, 1, '1, pat(56)); sleep = 0; tick;
      d_idle; tick;
      check("R12 after sleep", DW'(rdata_oe), DW'(0));
      read1(6'd20, "R1 no write in sleep");
      read1(6'd21, "R12 no write after sleep");
   endtask

   task automatic t_oe;
      d_idle; d_adsp(6'd21); tick; d_idle; tick;
      oe_n = 1; #1;
      check("R11 oe high", DW'(rdata_oe), DW'(0));
      oe_n = 0; #1;
      check("R11 oe low", DW'(rdata_oe), DW'(1));
      check("R11 data", rdata, refm[21]);
   endtask

   initial begin
      for (int i = 0; i < (1<<AW); i++) refm[i] = '0;
      d_idle; oe_n = 0; ilv_mode = 0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      check("R13 reset oe", DW'(rdata_oe), DW'(0));
      rst_n = 1; @(negedge clk);
      t_reset;
      t_write_burst;
      for (int i = 20; i < 24; i++) wr1(6'(i), pat(i));
      rd_burst(6'd22, 0, "R4 R8 linear");
      rd_burst(6'd21, 1, "R9 interleaved");
      rd_burst(6'd23, 1, "R9 interleaved base3");
      t_suspend;
      t_adsp_ignores_write;
      t_byte_mask;
      t_deselect;
      t_sleep;
      t_oe;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule